// File: doc/BRIEF.md
# Text-Mode Pixel Colour Resolver

This block turns one pixel of character data into a palette index for a character-based display. It sits after the character and colour-memory fetch stages and before the palette lookup: each cycle it receives the character data byte, the colour-memory byte of the current cell, and a set of per-cell and per-line controls. One clock later it presents an 8-bit palette index and a flag that says whether the pixel is foreground or transparent.

Two pixel formats are supported. In full-colour mode every pixel is a whole byte. In 16-colour mode every pixel is a nybble, so a data byte carries two pixels and a cell is 16 pixels wide. An extended-attribute enable reinterprets the upper bits of the colour-memory byte as blink and underline controls. It also narrows the cell colour used for the all-ones full-colour pixel code to four bits.

Top module: `txtpix_resolve`

## Requirements
- R1: With mode_i=0 (full colour), a pixel byte other than 0x00 and 0xFF produces fg_o=1 and index_o equal to the pixel byte, whatever the extended-attribute, blink and colour-memory inputs are, unless R7 applies.
- R2: With mode_i=0, pixel 0xFF and xattr_en_i=0, the output is fg_o=1 and index_o equal to the full 8-bit colour-memory byte.
- R3: With mode_i=0, pixel 0xFF and xattr_en_i=1, index_o is {4'h0, cram_i[3:0]}. fg_o=1 unless R4 applies.
- R4: With xattr_en_i=1, blink attribute cram_i[4]=1 and blink_phase_i=0, a full-colour 0xFF pixel gives fg_o=0. With blink_phase_i=1 it is shown as in R3. Blink has no effect on any other pixel code or in 16-colour mode.
- R5: A zero pixel gives fg_o=0 unless R7 applies; index_o is then unspecified. A zero pixel is a 0x00 byte in full-colour mode or a zero nybble in 16-colour mode.
- R6: With mode_i=1 (16 colour), nyb_sel_i=0 selects pix_i[3:0] (the left pixel) and nyb_sel_i=1 selects pix_i[7:4]. A nonzero nybble n gives fg_o=1 and index_o={cram_i[3:0], n}, independent of xattr_en_i.
- R7: With xattr_en_i=1, underline attribute cram_i[7]=1 and uline_row_i=1, every pixel in either mode gives fg_o=1 and index_o={4'h0, cram_i[3:0]}. This includes zero pixels, and underline takes precedence over blink.
- R8: Outputs appear exactly one clock after the inputs are sampled: valid_o follows valid_i one cycle later. After reset, valid_o, fg_o and index_o are 0. fg_o and index_o hold their value on cycles with valid_i=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input pixel present this cycle |
| mode_i | input | 1 | 0 = full colour (byte per pixel), 1 = 16 colour (nybble per pixel) |
| xattr_en_i | input | 1 | Extended attributes enable |
| blink_phase_i | input | 1 | Blink phase, 0 = blinking pixels hidden |
| uline_row_i | input | 1 | Current pixel row is the underline row |
| nyb_sel_i | input | 1 | 16-colour nybble select, 0 = low nybble (left pixel) |
| pix_i | input | 8 | Character data byte |
| cram_i | input | 8 | Colour-memory byte of the cell |
| valid_o | output | 1 | Output pixel valid |
| fg_o | output | 1 | 1 = foreground, 0 = transparent |
| index_o | output | 8 | Palette index |

## Verification
The assertions take every input to be a known value on any cycle where valid_i is high, with all fields of one pixel presented together in that cycle. They also expect valid_i to be low from reset until the first pixel. The stimulus changes inputs only on the falling clock edge and holds valid_i low through reset. It then sweeps every control combination against all 256 pixel bytes, and all 256 colour-memory bytes against the boundary pixel codes, so every attribute bit and both nybble positions are exercised.

// File: rtl/txtpix_pkg.sv
package txtpix_pkg;
  localparam int CLR_W     = 8;
  localparam int NYB_W     = CLR_W / 2;
  localparam int BLINK_BIT = 4;
  localparam int ULINE_BIT = 7;

  typedef enum logic {
    PM_FULL = 1'b0,
    PM_NYB  = 1'b1
  } pix_mode_e;

  typedef struct packed {
    logic             blink;
    logic             uline;
    logic [NYB_W-1:0] colour;
    logic [CLR_W-1:0] full;
  } cell_attr_t;
endpackage

// File: rtl/txtpix_nybble_sel.sv
module txtpix_nybble_sel
  import txtpix_pkg::*;
(
  input  logic [CLR_W-1:0] byte_i,
  input  logic             sel_i,
  output logic [NYB_W-1:0] nyb_o
);
  // low nybble is the left pixel
  assign nyb_o = sel_i ? byte_i[CLR_W-1:NYB_W] : byte_i[NYB_W-1:0];
endmodule

// File: rtl/txtpix_attr_decode.sv
module txtpix_attr_decode
  import txtpix_pkg::*;
(
  input  logic [CLR_W-1:0] cram_i,
  input  logic             xattr_en_i,
  output cell_attr_t       attr_o
);
  always_comb begin
    attr_o.full   = cram_i;
    attr_o.colour = cram_i[NYB_W-1:0];
    attr_o.blink  = xattr_en_i & cram_i[BLINK_BIT];
    attr_o.uline  = xattr_en_i & cram_i[ULINE_BIT];
  end
endmodule

// File: rtl/txtpix_merge.sv
module txtpix_merge
  import txtpix_pkg::*;
(
  input  pix_mode_e        mode_i,
  input  logic             xattr_en_i,
  input  logic             blink_phase_i,
  input  logic             uline_row_i,
  input  logic [CLR_W-1:0] pix_i,
  input  logic [NYB_W-1:0] nyb_i,
  input  cell_attr_t       attr_i,
  output logic             fg_o,
  output logic [CLR_W-1:0] index_o
);
  localparam logic [CLR_W-NYB_W-1:0] HI_ZERO = '0;

  always_comb begin
    fg_o    = 1'b0;
    index_o = '0;
    if (attr_i.uline && uline_row_i) begin
      fg_o    = 1'b1;
      index_o = {HI_ZERO, attr_i.colour};
    end else if (mode_i == PM_NYB) begin
      fg_o    = |nyb_i;
      index_o = {attr_i.colour, nyb_i};
    end else if (pix_i == '1) begin
      if (xattr_en_i) begin
        fg_o    = !(attr_i.blink && !blink_phase_i);
        index_o = {HI_ZERO, attr_i.colour};
      end else begin
        fg_o    = 1'b1;
        index_o = attr_i.full;
      end
    end else begin
      fg_o    = |pix_i;
      index_o = pix_i;
    end
  end
endmodule

// File: rtl/txtpix_resolve.sv
module txtpix_resolve
  import txtpix_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             mode_i,
  input  logic             xattr_en_i,
  input  logic             blink_phase_i,
  input  logic             uline_row_i,
  input  logic             nyb_sel_i,
  input  logic [CLR_W-1:0] pix_i,
  input  logic [CLR_W-1:0] cram_i,
  output logic             valid_o,
  output logic             fg_o,
  output logic [CLR_W-1:0] index_o
);
  logic [NYB_W-1:0] nyb;
  cell_attr_t       attr;
  logic             fg_d;
  logic [CLR_W-1:0] index_d;
  pix_mode_e        mode;

  assign mode = pix_mode_e'(mode_i);

  txtpix_nybble_sel u_nyb (
    .byte_i (pix_i),
    .sel_i  (nyb_sel_i),
    .nyb_o  (nyb)
  );

  txtpix_attr_decode u_attr (
    .cram_i     (cram_i),
    .xattr_en_i (xattr_en_i),
    .attr_o     (attr)
  );

  txtpix_merge u_merge (
    .mode_i        (mode),
    .xattr_en_i    (xattr_en_i),
    .blink_phase_i (blink_phase_i),
    .uline_row_i   (uline_row_i),
    .pix_i         (pix_i),
    .nyb_i         (nyb),
    .attr_i        (attr),
    .fg_o          (fg_d),
    .index_o       (index_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      fg_o    <= 1'b0;
      index_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        fg_o    <= fg_d;
        index_o <= index_d;
      end
    end
  end

  // port-level checks against the requirements
  logic ul_hit;
  assign ul_hit = xattr_en_i && cram_i[ULINE_BIT] && uline_row_i;

  p_valid_lat_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  p_idle_lat_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o && $stable(fg_o) && $stable(index_o));

  p_plain_pix_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !mode_i && !ul_hit && pix_i != '0 && pix_i != '1
    |=> fg_o && index_o == $past(pix_i));

  p_ff_full_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !mode_i && !xattr_en_i && pix_i == '1
    |=> fg_o && index_o == $past(cram_i));

  p_blink_hide_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !mode_i && !ul_hit && xattr_en_i && cram_i[BLINK_BIT]
      && !blink_phase_i && pix_i == '1
    |=> !fg_o);

  p_zero_bg_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !mode_i && !ul_hit && pix_i == '0 |=> !fg_o);

  p_nyb_index_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && mode_i && !ul_hit && nyb_sel_i && pix_i[CLR_W-1:NYB_W] != '0
    |=> fg_o && index_o == {$past(cram_i[NYB_W-1:0]), $past(pix_i[CLR_W-1:NYB_W])});

  p_uline_force_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && ul_hit
    |=> fg_o && index_o[CLR_W-1:NYB_W] == '0
        && index_o[NYB_W-1:0] == $past(cram_i[NYB_W-1:0]));
endmodule

// File: tb/txtpix_resolve_tb_top.sv
module txtpix_resolve_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       valid = 1'b0, mode = 1'b0, xattr = 1'b0, bphase = 1'b0;
  logic       ulrow = 1'b0, nsel = 1'b0;
  logic [7:0] pix = 8'h00, cram = 8'h00;
  logic       valid_o, fg_o;
  logic [7:0] index_o;
  int         n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  txtpix_resolve dut_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .mode_i(mode),
    .xattr_en_i(xattr), .blink_phase_i(bphase), .uline_row_i(ulrow),
    .nyb_sel_i(nsel), .pix_i(pix), .cram_i(cram),
    .valid_o(valid_o), .fg_o(fg_o), .index_o(index_o)
  );

  // expected {fg, index, tag} from the requirements
  function automatic void model(input int m, x, bp, ul, sl, p, c,
                                output int efg, output int eidx, output string tag);
    int nyb;
    efg = 0; eidx = 0;
    if (x == 1 && (c / 128) == 1 && ul == 1) begin
      efg = 1; eidx = c % 16; tag = "R7";
    end else if (m == 1) begin
      nyb = (sl == 1) ? p / 16 : p % 16;
      if (nyb == 0) tag = "R5";
      else begin efg = 1; eidx = (c % 16) * 16 + nyb; tag = "R6"; end
    end else if (p == 0) begin
      tag = "R5";
    end else if (p == 255) begin
      if (x == 0) begin efg = 1; eidx = c; tag = "R2"; end
      else if (((c / 16) % 2) == 1 && bp == 0) tag = "R4";
      else begin efg = 1; eidx = c % 16; tag = "R3"; end
    end else begin
      efg = 1; eidx = p; tag = "R1";
    end
  endfunction

  task automatic apply(input int m, x, bp, ul, sl, p, c);
    int efg, eidx;
    string tag;
    @(negedge clk);
    valid = 1'b1; mode = m[0]; xattr = x[0]; bphase = bp[0];
    ulrow = ul[0]; nsel = sl[0]; pix = p[7:0]; cram = c[7:0];
    model(m, x, bp, ul, sl, p, c, efg, eidx, tag);
    @(posedge clk); #1;
    n_chk++;
    if (valid_o !== 1'b1 || fg_o !== efg[0] || (efg == 1 && index_o !== eidx[7:0])) begin
      n_fail++;
      $display("FAIL %s: m=%0d x=%0d bp=%0d ul=%0d sel=%0d pix=%h cram=%h got v=%b fg=%b idx=%h exp fg=%0d idx=%h",
               tag, m, x, bp, ul, sl, p, c, valid_o, fg_o, index_o, efg, eidx[7:0]);
    end
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not complete, got timeout exp completion");
    finish_run();
  end

  initial begin
    int craml[8] = '{8'h00, 8'h0F, 8'h10, 8'h80, 8'h90, 8'hA5, 8'h7E, 8'hFF};
    int pixl[4]  = '{8'h00, 8'hFF, 8'h3C, 8'hF0};
    logic [7:0] held;
    repeat (3) @(posedge clk);
    #1;
    n_chk++; // R8 reset state
    if (valid_o !== 1'b0 || fg_o !== 1'b0 || index_o !== 8'h00) begin
      n_fail++;
      $display("FAIL R8 reset: got v=%b fg=%b idx=%h exp 0 0 00", valid_o, fg_o, index_o);
    end
    @(negedge clk); rst_n = 1'b1;

    // every control combination against every pixel byte
    for (int k = 0; k < 32; k++)
      for (int p = 0; p < 256; p++)
        for (int ci = 0; ci < 8; ci++)
          apply(k % 2, (k / 2) % 2, (k / 4) % 2, (k / 8) % 2, (k / 16) % 2, p, craml[ci]);

    // every colour-memory byte against boundary pixels
    for (int k = 0; k < 32; k++)
      for (int c = 0; c < 256; c++)
        for (int pi = 0; pi < 4; pi++)
          apply(k % 2, (k / 2) % 2, (k / 4) % 2, (k / 8) % 2, (k / 16) % 2, pixl[pi], c);

    // R8: idle cycle drops valid and holds data
    apply(0, 0, 0, 0, 0, 8'h5A, 8'h00);
    held = index_o;
    @(negedge clk); valid = 1'b0; pix = 8'h00; cram = 8'hFF;
    @(posedge clk); #1;
    n_chk++;
    if (valid_o !== 1'b0 || fg_o !== 1'b1 || index_o !== held) begin
      n_fail++;
      $display("FAIL R8 idle: got v=%b fg=%b idx=%h exp v=0 fg=1 idx=%h", valid_o, fg_o, index_o, held);
    end
    finish_run();
  end
endmodule